// File: doc/BRIEF.md
# Decimal Arithmetic Adjust Unit

This block corrects the result of a preceding binary add, subtract, multiply or divide so that it reads as decimal. It works on a 16-bit accumulator split into a high byte and a low byte. Packed decimal (two digits per byte) and unpacked decimal (one digit per byte, high nibble zero) are both supported. A 3-bit operation code picks one of six adjusts. The carry and auxiliary-carry flags left by the previous arithmetic step come in with the operands. An 8-bit base operand serves the two adjusts that split or merge digits around a multiply or divide.

The unit computes the new accumulator and a fresh set of carry, auxiliary, zero, parity and sign flags in one cycle. It captures them in a single output register stage, so every result appears one clock after its operands. Splitting by a zero base is reported on an error output; in that case the accumulator is left as it was. The arithmetic that comes before the adjust, and the register file, sit outside this block.

Top module: `bcd_adjust_unit`

## Requirements
- R1: While rst_n is low and after it is released, before any clocked operand, res_hi, res_lo, cf_out, af_out, sf_out and base_err are 0, and zf_out and pf_out are 1.
- R2: Every output reflects the inputs sampled at the previous rising clock edge. Changing the inputs between edges has no effect on the outputs until the next edge.
- R3: op_sel 0 (packed add adjust): when acc_lo[3:0] > 9 or af_in is 1, 6 is added to the low byte and af_out is 1. When the original acc_lo > 0x99 or cf_in is 1, 0x60 is also added and cf_out is 1. Any flag not set by these rules is 0. res_hi equals acc_hi. All sums wrap at 8 bits.
- R4: op_sel 1 (packed subtract adjust): when acc_lo[3:0] > 9 or af_in is 1, af_out is 1, 6 is subtracted, and cf_out is 1 if the original acc_lo < 6 or cf_in is 1. When the original acc_lo > 0x99 or cf_in is 1, 0x60 is subtracted and cf_out is 1. Flags not set are 0. res_hi equals acc_hi. All differences wrap at 8 bits.
- R5: op_sel 2 (unpacked add adjust), with acc_lo[3:0] > 9 or af_in 1: res_lo = (acc_lo + 6) mod 16. res_hi = acc_hi + 1, plus 1 more when acc_lo > 0xF9 (mod 256). cf_out and af_out are 1.
- R6: op_sel 3 (unpacked subtract adjust), under the same condition: res_lo = (acc_lo − 6) mod 16. res_hi = acc_hi − 1, minus 1 more when acc_lo < 6 (mod 256). cf_out and af_out are 1.
- R7: For op_sel 2 or 3 when acc_lo[3:0] <= 9 and af_in is 0: res_lo = acc_lo[3:0], res_hi = acc_hi, and cf_out and af_out are 0.
- R8: op_sel 4 (split after multiply) with base_in != 0: res_hi = acc_lo / base_in and res_lo = acc_lo mod base_in. cf_out and af_out are 0 and base_err is 0.
- R9: op_sel 4 with base_in == 0: base_err is 1, res_hi and res_lo equal acc_hi and acc_lo, and cf_out and af_out are 0. base_err is 0 for every other operation and base.
- R10: op_sel 5 (merge before divide): res_lo = (acc_hi × base_in + acc_lo) mod 256, res_hi = 0, and cf_out and af_out are 0.
- R11: For every op_sel, zf_out = (res_lo == 0), sf_out = res_lo[7], and pf_out = 1 exactly when res_lo has an even number of one bits.
- R12: op_sel 6 and 7 are pass-through: res_hi = acc_hi, res_lo = acc_lo, cf_out = cf_in, af_out = af_in, and base_err is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_sel | input | 3 | Adjust operation code (0 to 5 adjusts, 6 and 7 pass-through) |
| acc_hi | input | 8 | Accumulator high byte |
| acc_lo | input | 8 | Accumulator low byte |
| cf_in | input | 1 | Incoming carry flag |
| af_in | input | 1 | Incoming auxiliary-carry flag |
| base_in | input | 8 | Base for the split and merge adjusts |
| res_hi | output | 8 | New accumulator high byte |
| res_lo | output | 8 | New accumulator low byte |
| cf_out | output | 1 | New carry flag |
| af_out | output | 1 | New auxiliary-carry flag |
| zf_out | output | 1 | Zero flag of res_lo |
| pf_out | output | 1 | Even-parity flag of res_lo |
| sf_out | output | 1 | Sign flag (res_lo bit 7) |
| base_err | output | 1 | Split requested with a zero base |

## Verification
The bench sweeps every low-byte value with all four incoming flag combinations for the packed and unpacked adjusts, so the boundaries are all covered. These include the 0x99/0x9A and nibble 9/10 thresholds and the subtract borrow taken in the low step. A design that tested the high condition on the already-corrected byte, instead of the original byte, would miss or add an 0x60 correction near 0x9A. The unpacked add above 0xF9 and the unpacked subtract below 6 are targeted because each must move the high byte by two. A design without that extra step leaves the high byte off by one. The split and merge adjusts are swept over bases 0, 1, powers of two, 10 and 255. This catches a zero base that changes the accumulator or fails to flag, and a merge that does not wrap at 8 bits.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        ADJ_PACK_ADD  = 3'd0,
        ADJ_PACK_SUB  = 3'd1,
        ADJ_UNP_ADD   = 3'd2,
        ADJ_UNP_SUB   = 3'd3,
        ADJ_MUL_SPLIT = 3'd4,
        ADJ_DIV_MERGE = 3'd5,
        ADJ_RSV6      = 3'd6,
        ADJ_RSV7      = 3'd7
    } adj_op_e;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
        logic              cf;
        logic              af;
        logic              err;
    } adj_res_t;

endpackage

// File: rtl/packed_dec_fix.sv
module packed_dec_fix
    import bcd_adj_pkg::*;
(
    input  logic              sub_mode,
    input  logic [BYTE_W-1:0] lo_in,
    input  logic              cf_in,
    input  logic              af_in,
    output logic [BYTE_W-1:0] lo_out,
    output logic              cf_out,
    output logic              af_out
);
    localparam logic [NIB_W-1:0]  NIB_LIMIT  = NIB_W'(9);
    localparam logic [BYTE_W-1:0] LOW_FIX    = BYTE_W'(6);
    localparam logic [BYTE_W-1:0] HIGH_FIX   = BYTE_W'(8'h60);
    localparam logic [BYTE_W-1:0] HIGH_LIMIT = BYTE_W'(8'h99);

    logic low_hit;
    logic high_hit;

    // Both conditions look at the original byte, not the corrected one.
    assign low_hit  = (lo_in[NIB_W-1:0] > NIB_LIMIT) || af_in;
    assign high_hit = (lo_in > HIGH_LIMIT) || cf_in;

    always_comb begin
        lo_out = lo_in;
        cf_out = 1'b0;
        af_out = 1'b0;
        if (!sub_mode) begin
            if (low_hit) begin
                lo_out = lo_out + LOW_FIX;
                af_out = 1'b1;
            end
            if (high_hit) begin
                lo_out = lo_out + HIGH_FIX;
                cf_out = 1'b1;
            end
        end else begin
            if (low_hit) begin
                af_out = 1'b1;
                if ((lo_in < LOW_FIX) || cf_in) begin
                    cf_out = 1'b1;
                end
                lo_out = lo_out - LOW_FIX;
            end
            if (high_hit) begin
                lo_out = lo_out - HIGH_FIX;
                cf_out = 1'b1;
            end
        end
    end

endmodule

// File: rtl/unpacked_dec_fix.sv
module unpacked_dec_fix
    import bcd_adj_pkg::*;
(
    input  logic              sub_mode,
    input  logic [BYTE_W-1:0] hi_in,
    input  logic [BYTE_W-1:0] lo_in,
    input  logic              af_in,
    output logic [BYTE_W-1:0] hi_out,
    output logic [BYTE_W-1:0] lo_out,
    output logic              flag_out
);
    localparam logic [NIB_W-1:0]  NIB_LIMIT = NIB_W'(9);
    localparam logic [BYTE_W-1:0] LOW_FIX   = BYTE_W'(6);
    localparam logic [BYTE_W-1:0] ADD_WRAP  = BYTE_W'(8'hF9);
    localparam logic [BYTE_W-1:0] ONE       = BYTE_W'(1);

    logic              hit;
    logic              add_wrap;
    logic              sub_wrap;
    logic [BYTE_W-1:0] lo_sum;
    logic [BYTE_W-1:0] lo_dif;

    assign hit      = (lo_in[NIB_W-1:0] > NIB_LIMIT) || af_in;
    assign add_wrap = lo_in > ADD_WRAP;
    assign sub_wrap = lo_in < LOW_FIX;
    assign lo_sum   = lo_in + LOW_FIX;
    assign lo_dif   = lo_in - LOW_FIX;

    always_comb begin
        hi_out   = hi_in;
        lo_out   = {{NIB_W{1'b0}}, lo_in[NIB_W-1:0]};
        flag_out = 1'b0;
        if (hit) begin
            flag_out = 1'b1;
            if (!sub_mode) begin
                lo_out = {{NIB_W{1'b0}}, lo_sum[NIB_W-1:0]};
                hi_out = hi_in + ONE + {{(BYTE_W-1){1'b0}}, add_wrap};
            end else begin
                lo_out = {{NIB_W{1'b0}}, lo_dif[NIB_W-1:0]};
                hi_out = hi_in - ONE - {{(BYTE_W-1){1'b0}}, sub_wrap};
            end
        end
    end

endmodule

// File: rtl/base_scale_fix.sv
module base_scale_fix
    import bcd_adj_pkg::*;
(
    input  logic [BYTE_W-1:0] hi_in,
    input  logic [BYTE_W-1:0] lo_in,
    input  logic [BYTE_W-1:0] base,
    output logic [BYTE_W-1:0] quo,
    output logic [BYTE_W-1:0] rem,
    output logic [BYTE_W-1:0] merged,
    output logic              zero_base
);
    logic [BYTE_W:0] part;

    assign zero_base = (base == '0);

    // Merge: product and sum both wrap at the byte width.
    assign merged = (hi_in * base) + lo_in;

    // Restoring divider, one compare-subtract step per quotient bit.
    always_comb begin
        part = '0;
        quo  = '0;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            part = {part[BYTE_W-1:0], lo_in[i]};
            if (part >= {1'b0, base}) begin
                part   = part - {1'b0, base};
                quo[i] = 1'b1;
            end
        end
        rem = part[BYTE_W-1:0];
    end

endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
    import bcd_adj_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [BYTE_W-1:0] acc_hi,
    input  logic [BYTE_W-1:0] acc_lo,
    input  logic              cf_in,
    input  logic              af_in,
    input  logic [BYTE_W-1:0] base_in,
    output logic [BYTE_W-1:0] res_hi,
    output logic [BYTE_W-1:0] res_lo,
    output logic              cf_out,
    output logic              af_out,
    output logic              zf_out,
    output logic              pf_out,
    output logic              sf_out,
    output logic              base_err
);
    adj_op_e           op;
    adj_res_t          nxt;
    logic [BYTE_W-1:0] pk_lo;
    logic              pk_cf;
    logic              pk_af;
    logic [BYTE_W-1:0] up_hi;
    logic [BYTE_W-1:0] up_lo;
    logic              up_flag;
    logic [BYTE_W-1:0] bs_quo;
    logic [BYTE_W-1:0] bs_rem;
    logic [BYTE_W-1:0] bs_merged;
    logic              bs_zero;
    logic              seen_q;

    assign op = adj_op_e'(op_sel);

    packed_dec_fix u_packed (
        .sub_mode (op == ADJ_PACK_SUB),
        .lo_in    (acc_lo),
        .cf_in    (cf_in),
        .af_in    (af_in),
        .lo_out   (pk_lo),
        .cf_out   (pk_cf),
        .af_out   (pk_af)
    );

    unpacked_dec_fix u_unpacked (
        .sub_mode (op == ADJ_UNP_SUB),
        .hi_in    (acc_hi),
        .lo_in    (acc_lo),
        .af_in    (af_in),
        .hi_out   (up_hi),
        .lo_out   (up_lo),
        .flag_out (up_flag)
    );

    base_scale_fix u_scale (
        .hi_in     (acc_hi),
        .lo_in     (acc_lo),
        .base      (base_in),
        .quo       (bs_quo),
        .rem       (bs_rem),
        .merged    (bs_merged),
        .zero_base (bs_zero)
    );

    always_comb begin
        nxt.hi  = acc_hi;
        nxt.lo  = acc_lo;
        nxt.cf  = cf_in;
        nxt.af  = af_in;
        nxt.err = 1'b0;
        unique case (op)
            ADJ_PACK_ADD, ADJ_PACK_SUB: begin
                nxt.lo = pk_lo;
                nxt.cf = pk_cf;
                nxt.af = pk_af;
            end
            ADJ_UNP_ADD, ADJ_UNP_SUB: begin
                nxt.hi = up_hi;
                nxt.lo = up_lo;
                nxt.cf = up_flag;
                nxt.af = up_flag;
            end
            ADJ_MUL_SPLIT: begin
                nxt.cf = 1'b0;
                nxt.af = 1'b0;
                if (bs_zero) begin
                    nxt.err = 1'b1;
                end else begin
                    nxt.hi = bs_quo;
                    nxt.lo = bs_rem;
                end
            end
            ADJ_DIV_MERGE: begin
                nxt.hi = '0;
                nxt.lo = bs_merged;
                nxt.cf = 1'b0;
                nxt.af = 1'b0;
            end
            default: begin
                // reserved codes pass operands and flags through
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_hi   <= '0;
            res_lo   <= '0;
            cf_out   <= 1'b0;
            af_out   <= 1'b0;
            zf_out   <= 1'b1;
            pf_out   <= 1'b1;
            sf_out   <= 1'b0;
            base_err <= 1'b0;
            seen_q   <= 1'b0;
        end else begin
            res_hi   <= nxt.hi;
            res_lo   <= nxt.lo;
            cf_out   <= nxt.cf;
            af_out   <= nxt.af;
            zf_out   <= (nxt.lo == '0);
            pf_out   <= ~^nxt.lo;
            sf_out   <= nxt.lo[BYTE_W-1];
            base_err <= nxt.err;
            seen_q   <= 1'b1;
        end
    end

    // R11
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zf_out == (res_lo == '0));

    // R11
    sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sf_out == res_lo[BYTE_W-1]);

    // R10
    merge_hi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(op_sel) == ADJ_DIV_MERGE) |-> (res_hi == '0 && !cf_out && !af_out));

    // R7
    unp_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && ($past(op_sel) == ADJ_UNP_ADD || $past(op_sel) == ADJ_UNP_SUB))
        |-> (res_lo[BYTE_W-1:NIB_W] == '0 && cf_out == af_out));

    // R9
    base_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_err |-> (seen_q && $past(op_sel) == ADJ_MUL_SPLIT && $past(base_in) == '0));

    // R3
    pack_add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(op_sel) == ADJ_PACK_ADD && $past(cf_in)) |-> cf_out);

endmodule

// File: tb/test_bcd_adjust_unit.sv
`timescale 1ns/1ps
module test_bcd_adjust_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_sel = '0;
    logic [7:0] acc_hi = '0;
    logic [7:0] acc_lo = '0;
    logic       cf_in = 1'b0;
    logic       af_in = 1'b0;
    logic [7:0] base_in = '0;
    logic [7:0] res_hi;
    logic [7:0] res_lo;
    logic       cf_out;
    logic       af_out;
    logic       zf_out;
    logic       pf_out;
    logic       sf_out;
    logic       base_err;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #2 clk = ~clk;

    bcd_adjust_unit i_bcd_adjust_unit (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .acc_hi(acc_hi), .acc_lo(acc_lo),
        .cf_in(cf_in), .af_in(af_in), .base_in(base_in), .res_hi(res_hi), .res_lo(res_lo),
        .cf_out(cf_out), .af_out(af_out), .zf_out(zf_out), .pf_out(pf_out),
        .sf_out(sf_out), .base_err(base_err)
    );

    function automatic logic [21:0] pack_out(int h, int a, int c, int x, int e);
        logic [7:0] av = a[7:0];
        logic z = (av == 8'd0);
        logic p = ($countones(av) % 2) == 0;
        return {h[7:0], av, c[0], x[0], z, p, av[7], e[0]};
    endfunction

    function automatic logic [21:0] model(int op, int hi, int lo, int cf, int af, int base);
        int a = lo, h = hi, c = 0, x = 0, e = 0;
        bit low_c = ((lo % 16) > 9) || (af != 0);
        case (op)
            0: begin
                if (low_c) begin a = (a + 6) % 256; x = 1; end
                if (lo > 153 || cf != 0) begin a = (a + 96) % 256; c = 1; end
            end
            1: begin
                if (low_c) begin
                    x = 1;
                    if (lo < 6 || cf != 0) c = 1;
                    a = (a + 250) % 256;
                end
                if (lo > 153 || cf != 0) begin a = (a + 160) % 256; c = 1; end
            end
            2: begin
                if (low_c) begin
                    a = (lo + 6) % 16; h = (hi + 1 + (lo > 249 ? 1 : 0)) % 256; c = 1; x = 1;
                end else a = lo % 16;
            end
            3: begin
                if (low_c) begin
                    a = (lo + 250) % 16; h = (hi + 512 - 1 - (lo < 6 ? 1 : 0)) % 256; c = 1; x = 1;
                end else a = lo % 16;
            end
            4: begin
                if (base == 0) e = 1;
                else begin h = lo / base; a = lo % base; end
            end
            5: begin a = (hi * base + lo) % 256; h = 0; end
            default: begin c = cf; x = af; end
        endcase
        return pack_out(h, a, c, x, e);
    endfunction

    function automatic string tag_of(int op, int lo, int af, int base);
        bit low_c = ((lo % 16) > 9) || (af != 0);
        case (op)
            0: return "R3";
            1: return "R4";
            2: return low_c ? "R5" : "R7";
            3: return low_c ? "R6" : "R7";
            4: return (base == 0) ? "R9" : "R8";
            5: return "R10";
            default: return "R12";
        endcase
    endfunction

    function automatic int base_pick(int k);
        case (k)
            0: return 0;   1: return 1;   2: return 2;   3: return 9;
            4: return 10;  5: return 16;  6: return 127; default: return 255;
        endcase
    endfunction

    task automatic cmp(string tag, logic [21:0] got, logic [21:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s/R11 op=%0d hi=%02h lo=%02h cf=%0b af=%0b base=%02h got=%06h expected=%06h",
                     tag, op_sel, acc_hi, acc_lo, cf_in, af_in, base_in, got, exp);
        end
    endtask

    function automatic logic [21:0] sample();
        return {res_hi, res_lo, cf_out, af_out, zf_out, pf_out, sf_out, base_err};
    endfunction

    task automatic apply(int op, int hi, int lo, int cf, int af, int base);
        @(negedge clk);
        op_sel = op[2:0]; acc_hi = hi[7:0]; acc_lo = lo[7:0];
        cf_in = cf[0]; af_in = af[0]; base_in = base[7:0];
        @(negedge clk);
        cmp(tag_of(op, lo, af, base), sample(), model(op, hi, lo, cf, af, base));
    endtask

    initial begin
        // R1: reset state, during reset and right after release
        repeat (3) @(negedge clk);
        cmp("R1", sample(), 22'b0000_0000_0000_0000_00_1_1_0_0);
        rst_n = 1'b1;
        cmp("R1", sample(), 22'b0000_0000_0000_0000_00_1_1_0_0);

        // R2: inputs changed between edges do not reach the outputs early
        @(negedge clk);
        op_sel = 3'd5; acc_hi = 8'd3; acc_lo = 8'd4; base_in = 8'd10;
        #1;
        cmp("R2", sample(), pack_out(0, 0, 0, 0, 0));
        @(negedge clk);
        cmp("R2", sample(), model(5, 3, 4, 0, 0, 10));

        // R3 R4 R5 R6 R7: full low-byte sweep with every flag pair
        for (int op = 0; op < 4; op++)
            for (int lo = 0; lo < 256; lo++)
                for (int fl = 0; fl < 4; fl++)
                    apply(op, (lo * 7 + fl * 37) % 256, lo, fl / 2, fl % 2, 0);

        // R8 R9: split over a set of bases including zero
        for (int k = 0; k < 8; k++)
            for (int lo = 0; lo < 256; lo++)
                apply(4, (lo * 13) % 256, lo, lo % 2, (lo / 2) % 2, base_pick(k));

        // R10: merge, including wrap past 8 bits
        for (int k = 0; k < 8; k++)
            for (int hs = 0; hs < 6; hs++)
                for (int lo = 0; lo < 256; lo++)
                    apply(5, (hs == 5) ? 255 : hs * hs * 9 % 256, lo, 1, 1, base_pick(k));

        // R12: reserved codes pass through
        for (int op = 6; op < 8; op++)
            for (int i = 0; i < 64; i++)
                apply(op, (i * 29) % 256, (i * 53 + 7) % 256, i % 2, (i / 2) % 2, i);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, got=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule